// File: doc/BRIEF.md
# Configuration Strap Capture Unit

This block owns a group of dual-purpose pins. In normal operation each pin is an ordinary output carrying a functional signal from elsewhere in the chip. During a hard reset, the pins instead serve as configuration inputs. A hard reset is either the power-on reset or the external active-low chip reset. While either reset is held, every pin is tri-stated so that board resistors set its level. After both resets are released, the unit passes the pad levels through a two-flop synchronizer and waits a programmable settling window. It then latches the levels as default configuration bits and raises a valid flag. Only after that does it turn the output drivers on.

The latched configuration bits stay fixed until the next hard reset. Lighter resets elsewhere in the chip (software or bus-initiated) are not wired to this unit, so they can neither tri-state the pins nor cause a re-latch. Once the unit has captured, it never reads the pad inputs again.

Top module: `strap_capture_unit`

## Requirements
- R1: While `por_ni` or `chip_rst_ni` is low, `pad_oe_o`, `pad_out_o`, `strap_o` and `strap_valid_o` are all zero. Asserting either reset forces this state at once, without waiting for a clock edge.
- R2: Each reset input alone is enough to hold the unit in reset; the other input may be high.
- R3: Count rising edges from the point where both resets are high. With `pad_in_i` held stable, `strap_valid_o` rises on edge number `SETTLE_CYCLES`+3 and `strap_o` then equals `pad_in_i`. Bit i of `strap_o` comes from bit i of `pad_in_i`.
- R4: `pad_oe_o` stays all zero up to and including the edge on which `strap_valid_o` rises. On the next edge every bit of `pad_oe_o` becomes 1 together.
- R5: While `pad_oe_o` is on, `pad_out_o` equals `func_out_i` bit for bit, with no clock delay. While it is off, `pad_out_o` is zero whatever `func_out_i` is.
- R6: After capture, `strap_o` and `strap_valid_o` do not change for any change of `pad_in_i` or `func_out_i` until the next hard reset.
- R7: Each new hard reset re-latches the pad levels present at its release. This holds even if the new levels differ from those latched before.
- R8: If a hard reset is reasserted before capture completes, no capture takes place. The full settling window starts again at the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, active low |
| chip_rst_ni | input | 1 | External chip reset, active low |
| pad_in_i | input | NUM_STRAPS | Pad input levels |
| func_out_i | input | NUM_STRAPS | Functional output values for the pins |
| pad_oe_o | output | NUM_STRAPS | Pad output enables, 1 = drive |
| pad_out_o | output | NUM_STRAPS | Pad output data |
| strap_o | output | NUM_STRAPS | Latched configuration bits |
| strap_valid_o | output | 1 | Latched configuration bits are valid |

## Verification
An error in the settle counter or the sequencer state shows up as `strap_valid_o` rising one or more edges away from `SETTLE_CYCLES`+3, and it is caught in the first capture after reset. A sequencer that skips its capture step would show either enables turning on in the same cycle as `strap_valid_o` or wrong latched bits, and this is visible one edge later. A latch register that stays open after capture shows as a changed `strap_o` within three cycles of a pad change. A broken asynchronous clear shows as live enables while reset is held, and this appears at once, with no clock edge needed.

// File: rtl/strap_pkg.sv
package strap_pkg;

    typedef enum logic [1:0] {
        SC_SETTLE  = 2'd0,
        SC_CAPTURE = 2'd1,
        SC_RUN     = 2'd2
    } strap_state_e;

endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync (
    input  logic clk_i,
    input  logic por_ni,
    input  logic chip_rst_ni,
    output logic rst_no
);
    typedef struct packed {
        logic meta;
        logic sync;
    } rsync_t;

    rsync_t r_d, r_q;
    logic   hard_n;

    assign hard_n = por_ni & chip_rst_ni;

    always_comb begin
        r_d      = r_q;
        r_d.meta = 1'b1;
        r_d.sync = r_q.meta;
    end

    always_ff @(posedge clk_i or negedge hard_n) begin
        if (!hard_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rst_no = r_q.sync;
endmodule

// File: rtl/strap_in_sync.sv
module strap_in_sync #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [1:0] st_d, st_q;

        always_comb begin
            st_d    = st_q;
            st_d[0] = d_i[b];
            st_d[1] = st_q[0];
        end

        always_ff @(posedge clk_i) begin
            st_q <= st_d;
        end

        assign q_o[b] = st_q[1];
    end
endmodule

// File: rtl/strap_seq.sv
module strap_seq
    import strap_pkg::*;
#(
    parameter int unsigned NUM_STRAPS    = 4,
    parameter int unsigned SETTLE_CYCLES = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NUM_STRAPS-1:0] pad_sync_i,
    output logic [NUM_STRAPS-1:0] strap_o,
    output logic                  valid_o,
    output logic                  oe_on_o
);
    localparam int unsigned CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

    typedef struct packed {
        strap_state_e          state;
        logic [CNT_W-1:0]      cnt;
        logic [NUM_STRAPS-1:0] straps;
        logic                  valid;
        logic                  oe_on;
    } seq_t;

    localparam seq_t SEQ_RST = '{state: SC_SETTLE, cnt: '0, straps: '0, valid: 1'b0, oe_on: 1'b0};

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            SC_SETTLE: begin
                if (s_q.cnt == CNT_LAST) begin
                    s_d.state = SC_CAPTURE;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            SC_CAPTURE: begin
                s_d.straps = pad_sync_i;
                s_d.valid  = 1'b1;
                s_d.state  = SC_RUN;
            end
            SC_RUN: begin
                s_d.oe_on = 1'b1;
            end
            default: begin
                s_d = SEQ_RST;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= SEQ_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign strap_o = s_q.straps;
    assign valid_o = s_q.valid;
    assign oe_on_o = s_q.oe_on;
endmodule

// File: rtl/strap_pad_ctrl.sv
module strap_pad_ctrl #(
    parameter int unsigned NUM_STRAPS = 4
) (
    input  logic                  oe_on_i,
    input  logic [NUM_STRAPS-1:0] func_out_i,
    output logic [NUM_STRAPS-1:0] pad_oe_o,
    output logic [NUM_STRAPS-1:0] pad_out_o
);
    for (genvar p = 0; p < NUM_STRAPS; p++) begin : g_pin
        assign pad_oe_o[p]  = oe_on_i;
        assign pad_out_o[p] = oe_on_i & func_out_i[p];
    end
endmodule

// File: rtl/strap_capture_unit.sv
module strap_capture_unit #(
    parameter int unsigned NUM_STRAPS    = 4,
    parameter int unsigned SETTLE_CYCLES = 4
) (
    input  logic                  clk_i,
    input  logic                  por_ni,
    input  logic                  chip_rst_ni,
    input  logic [NUM_STRAPS-1:0] pad_in_i,
    input  logic [NUM_STRAPS-1:0] func_out_i,
    output logic [NUM_STRAPS-1:0] pad_oe_o,
    output logic [NUM_STRAPS-1:0] pad_out_o,
    output logic [NUM_STRAPS-1:0] strap_o,
    output logic                  strap_valid_o
);
    logic                  int_rst_n;
    logic [NUM_STRAPS-1:0] pad_sync;
    logic                  oe_on;

    strap_rst_sync i_rst_sync (
        .clk_i       (clk_i),
        .por_ni      (por_ni),
        .chip_rst_ni (chip_rst_ni),
        .rst_no      (int_rst_n)
    );

    strap_in_sync #(.WIDTH(NUM_STRAPS)) i_in_sync (
        .clk_i (clk_i),
        .d_i   (pad_in_i),
        .q_o   (pad_sync)
    );

    strap_seq #(.NUM_STRAPS(NUM_STRAPS), .SETTLE_CYCLES(SETTLE_CYCLES)) i_seq (
        .clk_i      (clk_i),
        .rst_ni     (int_rst_n),
        .pad_sync_i (pad_sync),
        .strap_o    (strap_o),
        .valid_o    (strap_valid_o),
        .oe_on_o    (oe_on)
    );

    strap_pad_ctrl #(.NUM_STRAPS(NUM_STRAPS)) i_pad_ctrl (
        .oe_on_i    (oe_on),
        .func_out_i (func_out_i),
        .pad_oe_o   (pad_oe_o),
        .pad_out_o  (pad_out_o)
    );
endmodule

// File: rtl/strap_capture_checker.sv
module strap_capture_checker #(
    parameter int unsigned NUM_STRAPS    = 4,
    parameter int unsigned SETTLE_CYCLES = 4
) (
    input logic                  clk_i,
    input logic                  por_ni,
    input logic                  chip_rst_ni,
    input logic [NUM_STRAPS-1:0] pad_oe_o,
    input logic [NUM_STRAPS-1:0] pad_out_o,
    input logic [NUM_STRAPS-1:0] strap_o,
    input logic                  strap_valid_o
);
    localparam int unsigned LAT   = SETTLE_CYCLES + 3;
    localparam int unsigned REL_W = $clog2(LAT + 2);
    localparam logic [REL_W-1:0] REL_MAX = REL_W'(LAT + 1);

    logic             hard_n;
    logic [REL_W-1:0] rel_q;

    assign hard_n = por_ni & chip_rst_ni;

    always_ff @(posedge clk_i or negedge hard_n) begin
        if (!hard_n) begin
            rel_q <= '0;
        end else if (rel_q != REL_MAX) begin
            rel_q <= rel_q + 1'b1;
        end
    end

    assert_tristate_in_reset_R1: assert property (@(posedge clk_i)
        !hard_n |-> (pad_oe_o == '0 && pad_out_o == '0 && !strap_valid_o));

    assert_capture_latency_R3: assert property (@(posedge clk_i) disable iff (!hard_n)
        $rose(strap_valid_o) |-> (rel_q == REL_W'(LAT)));

    assert_oe_after_capture_R4: assert property (@(posedge clk_i) disable iff (!hard_n)
        (pad_oe_o != '0) |-> $past(strap_valid_o));

    assert_oe_all_pins_R4: assert property (@(posedge clk_i) disable iff (!hard_n)
        ($countones(pad_oe_o) == 0) || ($countones(pad_oe_o) == NUM_STRAPS));

    assert_straps_hold_R6: assert property (@(posedge clk_i) disable iff (!hard_n)
        $past(strap_valid_o) |-> (strap_valid_o && $stable(strap_o)));
endmodule

bind strap_capture_unit strap_capture_checker #(
    .NUM_STRAPS    (NUM_STRAPS),
    .SETTLE_CYCLES (SETTLE_CYCLES)
) i_strap_chk (
    .clk_i         (clk_i),
    .por_ni        (por_ni),
    .chip_rst_ni   (chip_rst_ni),
    .pad_oe_o      (pad_oe_o),
    .pad_out_o     (pad_out_o),
    .strap_o       (strap_o),
    .strap_valid_o (strap_valid_o)
);

// File: tb/test_strap_capture_unit.sv
module test_strap_capture_unit;
    localparam int N      = 4;
    localparam int SETTLE = 4;
    localparam int LAT    = SETTLE + 3;
    localparam int NVEC   = 6;
    // upper nibble: pad level at reset, lower nibble: functional output
    localparam logic [7:0] VEC_TAB [NVEC] = '{8'hA5, 8'h3C, 8'h0F, 8'hF0, 8'h69, 8'h96};

    logic         clk = 1'b0;
    logic         por_n = 1'b0;
    logic         chip_n = 1'b0;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] func_out = '0;
    logic [N-1:0] pad_oe, pad_out, strap;
    logic         strap_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    strap_capture_unit #(.NUM_STRAPS(N), .SETTLE_CYCLES(SETTLE)) i_strap_capture_unit (
        .clk_i         (clk),
        .por_ni        (por_n),
        .chip_rst_ni   (chip_n),
        .pad_in_i      (pad_in),
        .func_out_i    (func_out),
        .pad_oe_o      (pad_oe),
        .pad_out_o     (pad_out),
        .strap_o       (strap),
        .strap_valid_o (strap_valid)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_quiet(input string req);
        check(pad_oe == '0, req, pad_oe, 0);
        check(pad_out == '0, req, pad_out, 0);
        check(strap == '0, req, strap, 0);
        check(strap_valid == 1'b0, req, strap_valid, 0);
    endtask

    // src 0: power-on reset only, 1: chip reset only, 2: both
    task automatic do_reset(input logic [N-1:0] pad, input int src);
        @(negedge clk);
        pad_in = pad;
        func_out = ~pad;
        if (src != 1) por_n = 1'b0;
        if (src != 0) chip_n = 1'b0;
        #1;
        check_quiet("R1");
        repeat (3) @(negedge clk);
        check_quiet("R2");
        por_n = 1'b1;
        chip_n = 1'b1;
    endtask

    task automatic wait_capture(input logic [N-1:0] pad, input string req);
        int n;
        n = 0;
        do begin
            @(posedge clk);
            #1;
            n++;
        end while (!strap_valid && n < 40);
        check(n == LAT, "R3", n, LAT);
        check(strap == pad, req, strap, pad);
        check(pad_oe == '0, "R4", pad_oe, 0);
        @(posedge clk);
        #1;
        check(pad_oe == '1, "R4", pad_oe, 4'hF);
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            finish_up();
        end
    end

    initial begin
        // reset state
        #1;
        check_quiet("R1");

        // table walk: alternate reset source
        for (int k = 0; k < NVEC; k++) begin
            do_reset(VEC_TAB[k][7:4], k % 3);
            wait_capture(VEC_TAB[k][7:4], "R7");
            @(negedge clk);
            func_out = VEC_TAB[k][3:0];
            #1;
            check(pad_out == VEC_TAB[k][3:0], "R5", pad_out, VEC_TAB[k][3:0]);
        end

        // r6_ pad and function changes after capture do not move straps
        do_reset(4'hB, 2);
        wait_capture(4'hB, "R3");
        @(negedge clk);
        pad_in = 4'h4;
        func_out = 4'h7;
        repeat (10) @(negedge clk);
        check(strap == 4'hB, "R6", strap, 4'hB);
        check(strap_valid == 1'b1, "R6", strap_valid, 1);
        check(pad_out == 4'h7, "R5", pad_out, 4'h7);
        func_out = 4'h2;
        #1;
        check(pad_out == 4'h2, "R5", pad_out, 4'h2);

        // R1: reset in mid-cycle drops drivers at once
        @(posedge clk);
        #2;
        por_n = 1'b0;
        #1;
        check(pad_oe == '0, "R1", pad_oe, 0);
        check(pad_out == '0, "R1", pad_out, 0);
        check(strap_valid == 1'b0, "R1", strap_valid, 0);
        func_out = 4'hF;
        #1;
        check(pad_out == '0, "R5", pad_out, 0);

        // R8: abort before capture restarts the window
        do_reset(4'h6, 1);
        repeat (LAT - 2) @(posedge clk);
        #1;
        check(strap_valid == 1'b0, "R8", strap_valid, 0);
        check(pad_oe == '0, "R8", pad_oe, 0);
        @(negedge clk);
        chip_n = 1'b0;
        #1;
        check(strap == '0, "R8", strap, 0);
        do_reset(4'h9, 1);
        wait_capture(4'h9, "R8");

        finish_up();
    end
endmodule